// File: doc/BRIEF.md
# Group Interrupt Dispatcher with Backlog

This block hands a group-targeted interrupt to one of the hardware threads that form a group. Each thread has a current processor priority. A smaller number means a more favoured priority, and 0xFF accepts everything. A request carries a priority and a group tag. It goes to a thread whose priority is less favoured than the request and that has no interrupt outstanding. The chosen thread's notification register then shows the group presentation code.

When no thread can take the request, it is not dropped. It is parked in a backlog that holds one entry per priority level. Every thread is shown the most favoured parked level. A thread that later relaxes its priority causes the backlog to be evaluated again, and the parked interrupt is presented to that thread. Acknowledging an interrupt clears the notification and raises the thread's priority to that of the interrupt. Software lowers it again with a priority write.

Top module: `grp_irq_dispatch`

## Requirements
- R1: While reset is asserted and right after it, every thread shows notification 0x00, priority 0xFF and backlog indicator 0xFF.
- R2: A thread is eligible when its priority register is numerically greater than the request priority and it holds no presented interrupt. An eligible thread that is chosen shows notification 0x82 from the cycle after the request.
- R3: Exactly one thread receives an interrupt, and it is the lowest-numbered eligible one. Every other thread keeps its notification unchanged.
- R4: When no thread is eligible, the request enters the backlog. All notifications stay 0x00, and from the next cycle every thread's backlog indicator equals the request priority.
- R5: With several levels parked, the backlog indicator shows the numerically lowest parked priority. It shows 0xFF once the backlog is empty.
- R6: A priority write takes effect at the next clock edge. The backlog is then evaluated with the new value, and at the following edge the best parked level goes to the lowest eligible thread. At that same edge the level is removed from the backlog. The written priority is kept.
- R7: An acknowledge on a thread with a presented interrupt clears its notification to 0x00 and loads its priority with the interrupt's priority at the next edge. This takes precedence over a priority write in the same cycle.
- R8: A priority write to a thread holding a presented interrupt changes its priority but leaves its notification at 0x82.
- R9: A request whose group tag differs from the block's group tag is ignored: nothing is presented and the backlog is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_valid_i | input | 1 | Interrupt request strobe |
| irq_prio_i | input | PRIO_W | Request priority, 0 most favoured |
| irq_tag_i | input | TAG_W | Group tag of the request |
| cppr_we_i | input | N_THR | Per-thread priority write strobe |
| cppr_wdata_i | input | N_THR x 8 | Per-thread priority write value |
| ack_i | input | N_THR | Per-thread acknowledge |
| nsr_o | output | N_THR x 8 | Per-thread notification, 0x82 presented, 0x00 idle |
| cppr_o | output | N_THR x 8 | Per-thread current priority |
| lsmfb_o | output | N_THR x 8 | Most favoured backlogged priority, 0xFF when empty |

## Verification
The dispatch function is tried with a series of priority patterns across the four threads. In one all threads are open. In others only higher-numbered threads are open. In others every thread blocks, either at a more favoured level or at exactly the request level. One pattern opens only the last thread. Together these separate the lowest-index choice from the eligibility compare, and a strict compare from a non-strict one. Directed sequences park one or two levels and then relax one thread at a time. They show which level is handed out first, that the indicator moves to the next level, and that it returns to 0xFF when the backlog empties. Further sequences cover a request hitting an already busy thread, acknowledge against a simultaneous priority write, and a request with a foreign tag.

// File: rtl/grp_disp_pkg.sv
package grp_disp_pkg;
  localparam int CPPR_W = 8;
  localparam logic [CPPR_W-1:0] NSR_GRP   = 8'h82;
  localparam logic [CPPR_W-1:0] NSR_IDLE  = 8'h00;
  localparam logic [CPPR_W-1:0] CPPR_OPEN = 8'hFF;
endpackage

// File: rtl/grp_lowest_set.sv
module grp_lowest_set #(
  parameter int W     = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/grp_thread_ctx.sv
module grp_thread_ctx
  import grp_disp_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              present_i,
  input  logic [PRIO_W-1:0] present_prio_i,
  input  logic              ack_i,
  input  logic              cppr_we_i,
  input  logic [CPPR_W-1:0] cppr_wdata_i,
  output logic              pend_o,
  output logic [CPPR_W-1:0] cppr_o,
  output logic [CPPR_W-1:0] nsr_o
);
  logic              pend_q;
  logic [PRIO_W-1:0] pprio_q;
  logic [CPPR_W-1:0] cppr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pprio_q <= '0;
      cppr_q  <= CPPR_OPEN;
    end else begin
      // ack outranks a same-cycle priority write
      if (ack_i && pend_q) begin
        pend_q <= 1'b0;
        cppr_q <= CPPR_W'(pprio_q);
      end else if (cppr_we_i) begin
        cppr_q <= cppr_wdata_i;
      end
      // present_i is only raised for a thread with no pending interrupt
      if (present_i) begin
        pend_q  <= 1'b1;
        pprio_q <= present_prio_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign cppr_o = cppr_q;
  assign nsr_o  = pend_q ? NSR_GRP : NSR_IDLE;
endmodule

// File: rtl/grp_irq_dispatch.sv
module grp_irq_dispatch
  import grp_disp_pkg::*;
#(
  parameter int               N_THR   = 4,
  parameter int               PRIO_W  = 3,
  parameter int               TAG_W   = 4,
  parameter logic [TAG_W-1:0] GRP_TAG = 4'h5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          irq_valid_i,
  input  logic [PRIO_W-1:0]             irq_prio_i,
  input  logic [TAG_W-1:0]              irq_tag_i,
  input  logic [N_THR-1:0]              cppr_we_i,
  input  logic [N_THR-1:0][CPPR_W-1:0]  cppr_wdata_i,
  input  logic [N_THR-1:0]              ack_i,
  output logic [N_THR-1:0][CPPR_W-1:0]  nsr_o,
  output logic [N_THR-1:0][CPPR_W-1:0]  cppr_o,
  output logic [N_THR-1:0][CPPR_W-1:0]  lsmfb_o
);
  localparam int NPRIO  = 1 << PRIO_W;
  localparam int TIDX_W = $clog2(N_THR);

  logic [NPRIO-1:0]  backlog_q, backlog_d;
  logic              bl_found;
  logic [PRIO_W-1:0] bl_idx;
  logic              req_hit, use_new, cand_valid, dispatch;
  logic [PRIO_W-1:0] cand_prio;
  logic [N_THR-1:0]  pend, elig, present;
  logic              any_elig;
  logic [TIDX_W-1:0] pick_idx;

  grp_lowest_set #(.W(NPRIO)) u_bl_enc (
    .vec_i   (backlog_q),
    .found_o (bl_found),
    .idx_o   (bl_idx)
  );

  assign req_hit    = irq_valid_i && (irq_tag_i == GRP_TAG);
  // fresh request competes with the best parked level; ties go to the fresh one
  assign use_new    = req_hit && (!bl_found || (irq_prio_i <= bl_idx));
  assign cand_valid = req_hit || bl_found;
  assign cand_prio  = use_new ? irq_prio_i : bl_idx;

  grp_lowest_set #(.W(N_THR)) u_pick (
    .vec_i   (elig),
    .found_o (any_elig),
    .idx_o   (pick_idx)
  );

  assign dispatch = cand_valid && any_elig;

  generate
    for (genvar t = 0; t < N_THR; t++) begin : g_thr
      assign elig[t]    = !pend[t] && (cppr_o[t] > CPPR_W'(cand_prio));
      assign present[t] = dispatch && (pick_idx == TIDX_W'(t));

      grp_thread_ctx #(.PRIO_W(PRIO_W)) u_ctx (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .present_i      (present[t]),
        .present_prio_i (cand_prio),
        .ack_i          (ack_i[t]),
        .cppr_we_i      (cppr_we_i[t]),
        .cppr_wdata_i   (cppr_wdata_i[t]),
        .pend_o         (pend[t]),
        .cppr_o         (cppr_o[t]),
        .nsr_o          (nsr_o[t])
      );

      assign lsmfb_o[t] = bl_found ? CPPR_W'(bl_idx) : CPPR_OPEN;
    end
  endgenerate

  always_comb begin
    backlog_d = backlog_q;
    if (req_hit && !(use_new && any_elig)) backlog_d[irq_prio_i] = 1'b1;
    if (!use_new && bl_found && any_elig)  backlog_d[bl_idx]     = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) backlog_q <= '0;
    else         backlog_q <= backlog_d;
  end
endmodule

// File: rtl/grp_irq_dispatch_chk.sv
module grp_irq_dispatch_chk #(
  parameter int               N_THR   = 4,
  parameter int               PRIO_W  = 3,
  parameter int               TAG_W   = 4,
  parameter logic [TAG_W-1:0] GRP_TAG = 4'h5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     irq_valid_i,
  input logic [PRIO_W-1:0]        irq_prio_i,
  input logic [TAG_W-1:0]         irq_tag_i,
  input logic [N_THR-1:0]         cppr_we_i,
  input logic [N_THR-1:0]         ack_i,
  input logic [N_THR-1:0][7:0]    nsr_o,
  input logic [N_THR-1:0][7:0]    cppr_o,
  input logic [N_THR-1:0][7:0]    lsmfb_o
);
  logic [N_THR-1:0] pres, pres_q, new_pres;

  always_comb begin
    for (int i = 0; i < N_THR; i++) pres[i] = (nsr_o[i] == 8'h82);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pres_q <= '0;
    else         pres_q <= pres;
  end

  assign new_pres = pres & ~pres_q;

  assert_one_target_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(new_pres));

  assert_park_when_blocked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_i && irq_tag_i == GRP_TAG) |=>
      ((new_pres != '0) || (lsmfb_o[0] <= 8'($past(irq_prio_i)))));

  assert_foreign_tag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(irq_valid_i && irq_tag_i == GRP_TAG) && lsmfb_o[0] == 8'hFF) |=> (new_pres == '0));

  generate
    for (genvar t = 0; t < N_THR; t++) begin : g_chk
      assert_reset_state_R1: assert property (@(posedge clk_i)
        !rst_ni |-> (nsr_o[t] == 8'h00 && cppr_o[t] == 8'hFF && lsmfb_o[t] == 8'hFF));

      assert_ack_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i[t] && pres[t]) |=> (nsr_o[t] == 8'h00));

      assert_write_keeps_nsr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cppr_we_i[t] && !ack_i[t] && pres[t]) |=> pres[t]);
    end
  endgenerate
endmodule

bind grp_irq_dispatch grp_irq_dispatch_chk #(
  .N_THR(N_THR), .PRIO_W(PRIO_W), .TAG_W(TAG_W), .GRP_TAG(GRP_TAG)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_valid_i (irq_valid_i),
  .irq_prio_i  (irq_prio_i),
  .irq_tag_i   (irq_tag_i),
  .cppr_we_i   (cppr_we_i),
  .ack_i       (ack_i),
  .nsr_o       (nsr_o),
  .cppr_o      (cppr_o),
  .lsmfb_o     (lsmfb_o)
);

// File: tb/sim_grp_irq_dispatch.sv
module sim_grp_irq_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] TAG_OK  = 4'h5;
  localparam logic [3:0] TAG_BAD = 4'h9;
  localparam int NVEC = 9;
  // {cppr t0, t1, t2, t3, prio(4), expected present mask(4), expected lsmfb}
  localparam logic [47:0] VEC [NVEC] = '{
    48'hFFFFFFFF_5_1_FF,
    48'h02FFFFFF_3_2_FF,
    48'h0202FFFF_3_4_FF,
    48'h020202FF_3_8_FF,
    48'h02020202_3_0_03,
    48'h04040404_4_0_04,
    48'h00000005_4_8_FF,
    48'h00000000_0_0_00,
    48'h07FFFFFF_7_2_FF
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic irq_valid = 1'b0;
  logic [2:0] irq_prio = '0;
  logic [3:0] irq_tag = TAG_OK;
  logic [3:0] cppr_we = '0;
  logic [3:0][7:0] cppr_wdata = '0;
  logic [3:0] ack = '0;
  logic [3:0][7:0] nsr, cppr, lsmfb;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  grp_irq_dispatch u0 (
    .clk_i (clk), .rst_ni (rst_ni), .irq_valid_i (irq_valid), .irq_prio_i (irq_prio),
    .irq_tag_i (irq_tag), .cppr_we_i (cppr_we), .cppr_wdata_i (cppr_wdata),
    .ack_i (ack), .nsr_o (nsr), .cppr_o (cppr), .lsmfb_o (lsmfb)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    tick();
    tick();
    rst_ni = 1'b1;
  endtask

  task automatic wr_cppr(input logic [3:0] we, input logic [7:0] c0, input logic [7:0] c1,
                         input logic [7:0] c2, input logic [7:0] c3);
    cppr_we = we;
    cppr_wdata = {c3, c2, c1, c0};
    tick();
    cppr_we = '0;
  endtask

  task automatic send(input logic [2:0] p, input logic [3:0] tag);
    irq_valid = 1'b1;
    irq_prio = p;
    irq_tag = tag;
    tick();
    irq_valid = 1'b0;
    irq_tag = TAG_OK;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1;
    rst_ni = 1'b0;
    @(negedge clk);
    tick();
    // R1 reset state
    for (int t = 0; t < 4; t++) begin
      chk("R1 nsr", nsr[t], 8'h00);
      chk("R1 cppr", cppr[t], 8'hFF);
      chk("R1 lsmfb", lsmfb[t], 8'hFF);
    end
    rst_ni = 1'b1;
    tick();

    // vector table: R2 eligibility, R3 lowest index, R4 parking
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      wr_cppr(4'hF, VEC[v][47:40], VEC[v][39:32], VEC[v][31:24], VEC[v][23:16]);
      send(VEC[v][14:12], TAG_OK);
      for (int t = 0; t < 4; t++)
        chk($sformatf("R2/R3 vec%0d thread%0d nsr", v, t), nsr[t],
            VEC[v][8 + t] ? 8'h82 : 8'h00);
      chk($sformatf("R4 vec%0d lsmfb", v), lsmfb[3], VEC[v][7:0]);
    end

    // R6 backlog re-evaluated after relax, R7 ack, then priority reset
    do_reset();
    wr_cppr(4'hF, 8'h02, 8'h02, 8'h02, 8'h02);
    send(3'd3, TAG_OK);
    for (int t = 0; t < 4; t++) chk("R4 parked lsmfb", lsmfb[t], 8'h03);
    wr_cppr(4'h8, 8'h00, 8'h00, 8'h00, 8'h04);
    chk("R6 not yet presented", nsr[3], 8'h00);
    chk("R6 cppr written", cppr[3], 8'h04);
    tick();
    chk("R6 presented to relaxed thread", nsr[3], 8'h82);
    chk("R6 cppr kept", cppr[3], 8'h04);
    chk("R6 other thread idle", nsr[0], 8'h00);
    chk("R6 backlog cleared", lsmfb[0], 8'hFF);
    ack = 4'h8;
    tick();
    ack = '0;
    chk("R7 ack nsr", nsr[3], 8'h00);
    chk("R7 ack cppr", cppr[3], 8'h03);
    wr_cppr(4'h8, 8'h00, 8'h00, 8'h00, 8'hFF);
    chk("R5 final nsr", nsr[3], 8'h00);
    chk("R5 final cppr", cppr[3], 8'hFF);
    chk("R5 final lsmfb", lsmfb[3], 8'hFF);

    // R5 two parked levels
    do_reset();
    wr_cppr(4'hF, 8'h00, 8'h00, 8'h00, 8'h00);
    send(3'd5, TAG_OK);
    send(3'd2, TAG_OK);
    chk("R5 lowest parked", lsmfb[1], 8'h02);
    wr_cppr(4'h2, 8'h00, 8'h03, 8'h00, 8'h00);
    tick();
    chk("R5 level 2 to thread1", nsr[1], 8'h82);
    chk("R5 next level shown", lsmfb[0], 8'h05);
    wr_cppr(4'h4, 8'h00, 8'h00, 8'hFF, 8'h00);
    tick();
    chk("R5 level 5 to thread2", nsr[2], 8'h82);
    chk("R5 thread0 idle", nsr[0], 8'h00);
    chk("R5 thread3 idle", nsr[3], 8'h00);
    chk("R5 backlog empty", lsmfb[2], 8'hFF);

    // R3 busy thread skipped, R8 write on busy thread, R7 ack beats write
    do_reset();
    send(3'd5, TAG_OK);
    chk("R3 first to thread0", nsr[0], 8'h82);
    send(3'd1, TAG_OK);
    chk("R3 second to thread1", nsr[1], 8'h82);
    chk("R3 thread0 still busy", nsr[0], 8'h82);
    chk("R3 thread2 idle", nsr[2], 8'h00);
    wr_cppr(4'h1, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R8 nsr kept", nsr[0], 8'h82);
    chk("R8 cppr written", cppr[0], 8'h00);
    ack = 4'h2;
    wr_cppr(4'h2, 8'h00, 8'h07, 8'h00, 8'h00);
    ack = '0;
    chk("R7 ack wins cppr", cppr[1], 8'h01);
    chk("R7 ack wins nsr", nsr[1], 8'h00);

    // R9 foreign tag
    do_reset();
    send(3'd2, TAG_BAD);
    for (int t = 0; t < 4; t++) chk("R9 nsr", nsr[t], 8'h00);
    chk("R9 lsmfb", lsmfb[0], 8'hFF);
    tick();
    chk("R9 no late presentation", nsr[0], 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule